// File: doc/BRIEF.md
# Min/Max Peak-Detect Decimator

This block sits behind a sampling front end that always runs at its fastest rate. It turns that full-rate stream of unsigned samples into a slower stream of output points. Each point stands for a fixed number of consecutive input samples, and that number is set by a ratio input. The block does not filter and then keep one sample in N. Each point instead reports the smallest and the largest sample in its window. A display drawing each point as a vertical bar from min to max therefore shows fast content as a band, and does not show it as a false low-frequency trace.

Input samples arrive on a bus with a valid qualifier. A cycle with the qualifier low moves nothing forward. When the last sample of a window is accepted, the block pulses an output valid for one cycle on the following cycle, with the min and max of that window. The ratio is read only when a window starts, so the host may change it at any time. Reset is synchronous. It throws away a partial window.

Top module: `minmax_decimator`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) drives outValid, outMin and outMax to 0, clears the window count, and throws away any partial window.
- R2: With an effective ratio N, outValid is high for exactly one cycle. That cycle is the one after the Nth accepted sample of a window. No pulse follows the other samples of the window.
- R3: On each outValid pulse, outMin equals the smallest and outMax the largest unsigned sample of that window.
- R4: With ratio 1, every accepted sample produces a pulse with outMin = outMax = that sample.
- R5: A ratio value of 0 is treated as 1.
- R6: The ratio is sampled at the first accepted sample of a window. A change during a window affects only the windows that start later.
- R7: Cycles with inValid low neither advance the window nor cause a pulse.
- R8: The first sample of a window loads min and max directly, so values from earlier windows never appear in a later point.
- R9: outMin and outMax hold their values between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Sample qualifier |
| inSample | input | 12 | Unsigned input sample |
| ratio | input | 16 | Input samples per output point (0 acts as 1) |
| outValid | output | 1 | One-cycle pulse marking a new point |
| outMin | output | 12 | Minimum of the last completed window |
| outMax | output | 12 | Maximum of the last completed window |

## Verification
The bench targets the window boundary in several ways. A ratio changed mid-window must not cut that window short, since a design reading the ratio live would pulse early. A window whose values sit above the previous window's minimum must report its own minimum, since a design that does not reload on the first sample would carry the old extreme forward. Idle gaps inside a window, ratio 0 and ratio 1, and a reset in the middle of a window are also driven. A design that counts idle cycles, divides by zero, or keeps a stale partial count would give a pulse at the wrong time or values that are wrong.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  typedef struct packed {
    logic take;   // a sample is accepted this cycle
    logic first;  // accepted sample opens a window
    logic last;   // accepted sample closes a window
  } mmdStrobes_t;
endpackage

// File: rtl/mmd_control.sv
module mmd_control
  import mmd_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [RATIO_W-1:0] ratio,
  output mmdStrobes_t        strobes,
  output logic               outValid
);
  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] cntQ;
  logic [RATIO_W-1:0] lenQ;
  logic [RATIO_W-1:0] effRatio;
  logic [RATIO_W-1:0] lenNow;
  logic               atStart;
  logic               isLast;
  logic [RATIO_W:0]   cntPlus;

  always_comb begin
    effRatio = (ratio == '0) ? ONE : ratio;
    atStart  = (cntQ == '0);
    lenNow   = atStart ? effRatio : lenQ;
    cntPlus  = {1'b0, cntQ} + 1'b1;
    isLast   = (cntPlus == {1'b0, lenNow});
    strobes.take  = inValid;
    strobes.first = inValid && atStart;
    strobes.last  = inValid && isLast;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ     <= '0;
      lenQ     <= ONE;
      outValid <= 1'b0;
    end else begin
      outValid <= strobes.last;
      if (strobes.first) lenQ <= effRatio;
      if (strobes.take) cntQ <= strobes.last ? '0 : cntPlus[RATIO_W-1:0];
    end
  end

  // R2: the count stays below the latched window length mid-window
  assert_cnt_in_window_R2: assert property (@(posedge clk) disable iff (rst)
    (cntQ != '0) |-> (cntQ < lenQ));
  // R6: the window length is frozen while a window is open
  assert_ratio_held_R6: assert property (@(posedge clk) disable iff (rst)
    (cntQ != '0) |=> $stable(lenQ));
  // R7: a pulse always follows an accepted sample
  assert_pulse_needs_sample_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(outValid) |-> $past(inValid));
endmodule

// File: rtl/mmd_datapath.sv
module mmd_datapath
  import mmd_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  mmdStrobes_t         strobes,
  input  logic [SAMPLE_W-1:0] inSample,
  output logic [SAMPLE_W-1:0] outMin,
  output logic [SAMPLE_W-1:0] outMax
);
  logic [SAMPLE_W-1:0] minQ, maxQ;
  logic [SAMPLE_W-1:0] nextMin, nextMax;
  logic                cleanQ;

  always_comb begin
    if (strobes.first) begin
      nextMin = inSample;
      nextMax = inSample;
    end else begin
      nextMin = (inSample < minQ) ? inSample : minQ;
      nextMax = (inSample > maxQ) ? inSample : maxQ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      minQ   <= '0;
      maxQ   <= '0;
      outMin <= '0;
      outMax <= '0;
      cleanQ <= 1'b0;
    end else begin
      cleanQ <= 1'b1;
      if (strobes.take) begin
        minQ <= nextMin;
        maxQ <= nextMax;
      end
      if (strobes.last) begin
        outMin <= nextMin;
        outMax <= nextMax;
      end
    end
  end

  // R3: a published point is never inverted
  assert_min_le_max_R3: assert property (@(posedge clk) disable iff (rst)
    cleanQ |-> (outMin <= outMax));
  // R9: published values move only on a closing sample
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (cleanQ && !$past(strobes.last)) |-> ($stable(outMin) && $stable(outMax)));
  // R8: a window-opening sample sits inside the running range
  assert_first_loads_R8: assert property (@(posedge clk) disable iff (rst)
    strobes.first |=> (minQ == maxQ));
endmodule

// File: rtl/minmax_decimator.sv
module minmax_decimator
  import mmd_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int RATIO_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic [RATIO_W-1:0]  ratio,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outMin,
  output logic [SAMPLE_W-1:0] outMax
);
  mmdStrobes_t strobes;

  mmd_control #(.RATIO_W(RATIO_W)) u_control (
    .clk(clk), .rst(rst), .inValid(inValid), .ratio(ratio),
    .strobes(strobes), .outValid(outValid)
  );

  mmd_datapath #(.SAMPLE_W(SAMPLE_W)) u_datapath (
    .clk(clk), .rst(rst), .strobes(strobes), .inSample(inSample),
    .outMin(outMin), .outMax(outMax)
  );
endmodule

// File: tb/minmax_decimator_tb.sv
module minmax_decimator_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [11:0] inSample = '0;
  logic [15:0] ratio = 16'd1;
  logic        outValid;
  logic [11:0] outMin, outMax;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  minmax_decimator u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .ratio(ratio), .outValid(outValid), .outMin(outMin), .outMax(outMax)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive one sample, then look at the outputs just after the accepting edge
  task automatic send(input int s, input bit expPulse, input int eMin, input int eMax,
                      input string tag);
    @(negedge clk);
    inValid  = 1'b1;
    inSample = 12'(s);
    @(posedge clk); #1;
    check(outValid == expPulse, {tag, " outValid"}, int'(outValid), int'(expPulse));
    if (expPulse) begin
      check(outMin == 12'(eMin), {tag, " outMin"}, int'(outMin), eMin);
      check(outMax == 12'(eMax), {tag, " outMax"}, int'(outMax), eMax);
    end
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk); #1;
    check(outValid == 1'b0, {tag, " single pulse R2"}, int'(outValid), 0);
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; inValid = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    #1;
    check(outValid == 0, "R1 outValid", int'(outValid), 0);
    check(outMin == 0, "R1 outMin", int'(outMin), 0);
    check(outMax == 0, "R1 outMax", int'(outMax), 0);
  endtask

  task automatic t_ratio1();
    ratio = 16'd1;
    send(5, 1, 5, 5, "R4 a");
    send(4095, 1, 4095, 4095, "R4 b");
    send(0, 1, 0, 0, "R4 c");
  endtask

  task automatic t_ratio4();
    ratio = 16'd4;
    send(100, 0, 0, 0, "R2 w1s1");
    send(4000, 0, 0, 0, "R2 w1s2");
    send(7, 0, 0, 0, "R2 w1s3");
    send(50, 1, 7, 4000, "R3 w1");
    send(3000, 0, 0, 0, "R8 w2s1");
    send(3001, 0, 0, 0, "R8 w2s2");
    send(2999, 0, 0, 0, "R8 w2s3");
    send(3000, 1, 2999, 3001, "R8 w2");
    send(0, 0, 0, 0, "R3 ext1");
    send(4095, 0, 0, 0, "R3 ext2");
    send(10, 0, 0, 0, "R3 ext3");
    send(20, 1, 0, 4095, "R3 extremes");
  endtask

  task automatic t_idle();
    ratio = 16'd3;
    send(600, 0, 0, 0, "R7 s1");
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      check(outValid == 0, "R7 idle no pulse", int'(outValid), 0);
      check(outMin == 0 && outMax == 4095, "R9 hold", int'(outMin), 0);
    end
    send(200, 0, 0, 0, "R7 s2");
    send(900, 1, 200, 900, "R7 close");
  endtask

  task automatic t_ratio0();
    ratio = 16'd0;
    send(321, 1, 321, 321, "R5 a");
    send(123, 1, 123, 123, "R5 b");
  endtask

  task automatic t_change();
    ratio = 16'd4;
    send(10, 0, 0, 0, "R6 s1");
    send(11, 0, 0, 0, "R6 s2");
    ratio = 16'd2;
    send(12, 0, 0, 0, "R6 s3 old ratio kept");
    send(13, 1, 10, 13, "R6 s4");
    send(14, 0, 0, 0, "R6 n1");
    send(15, 1, 14, 15, "R6 new ratio");
  endtask

  task automatic t_resetMid();
    ratio = 16'd3;
    send(4095, 0, 0, 0, "R1 p1");
    send(4095, 0, 0, 0, "R1 p2");
    doReset();
    #1;
    check(outMax == 0, "R1 mid reset outMax", int'(outMax), 0);
    send(10, 0, 0, 0, "R1 n1");
    send(20, 0, 0, 0, "R1 n2");
    send(30, 1, 10, 30, "R1 partial discarded");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_ratio1();
        t_ratio4();
        t_idle();
        t_ratio0();
        t_change();
        t_resetMid();
      end
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule